// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block sits between a synchronous request source and one asynchronous static RAM. It turns a single-cycle write request carrying an address and a data word into a write cycle on the memory pins whose edges land on clock edges. The RAM has an active-low chip select, an active-high chip select, an active-low write enable and an output enable.

The memory's minimum timings are kept in nanoseconds for two speed grades and converted to whole clock cycles from the clock-period parameter. All three write strobes are driven from one register, so the write starts and ends on a single edge. The length of the write pulse is the longest of the constraints that end at the end of write.

When the memory's output enable is held low during writes, the data pins are driven only after the memory's output driver has had time to let go of the bus. The sequencer releases them on the edge that ends the write. The requester sees a one-cycle acknowledge once the full write-cycle time has elapsed. Requests that arrive before that are dropped.

Top module: `sram_wr_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are `sram_cs1_n_o`=1, `sram_cs2_o`=0, `sram_we_n_o`=1, `sram_dq_oe_o`=0 and `ack_o`=0, and they stay at these values until a request is accepted.
- R2: A request is accepted on a clock edge where `req_i` is high and no write is in progress. On that same edge the captured address appears on `sram_addr_o`, `sram_cs1_n_o` goes low, `sram_cs2_o` goes high and `sram_we_n_o` goes low.
- R3: The three strobes stay asserted for exactly P cycles and deassert together on one edge. P = max(WPc, AWc, CWc, H + DWc). Here WPc, AWc, CWc and DWc are the rounded write-pulse, address-to-end, select-to-end and data-setup times, and H is defined in R4.
- R4: With `OE_TIED_LOW`=1, `sram_oe_n_o` is constantly 0 and `sram_dq_oe_o` rises H = HZc cycles after write start, where HZc is the rounded output-to-high-Z time. With `OE_TIED_LOW`=0, `sram_oe_n_o` is constantly 1, H = 0, and the data pins are driven from write start.
- R5: `sram_dq_oe_o` falls on the same edge on which `sram_we_n_o` rises, and it is never high while `sram_we_n_o` is high.
- R6: `ack_o` is high for exactly one cycle, on the edge W = max(WCc, P) cycles after the accepting edge, where WCc is the rounded write-cycle time.
- R7: From the accepting edge through the acknowledge, `sram_addr_o` holds the accepted address. While `sram_dq_oe_o` is high, `sram_dq_o` holds the accepted data.
- R8: A request seen while a write is in progress, including on the edge where `ack_o` rises, is ignored. It starts no write and does not change the address or data.
- R9: `SPEED_GRADE`=0 uses the fast-grade times: cycle 85, pulse 55, address-to-end 75, select-to-end 75, data setup 40, high-Z 30 ns. `SPEED_GRADE`=1 uses the slow-grade times: 100, 60, 80, 80, 40, 35 ns.
- R10: Each time is rounded up to whole cycles as ceil(ns / `CLK_PERIOD_NS`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, sampled when idle |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle write-complete pulse |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_dq_o | output | DATA_W | Memory data pins, output value |
| sram_dq_oe_o | output | 1 | Tri-state enable for the data pins |
| sram_cs1_n_o | output | 1 | Active-low chip select |
| sram_cs2_o | output | 1 | Active-high chip select |
| sram_we_n_o | output | 1 | Active-low write enable |
| sram_oe_n_o | output | 1 | Memory output enable, constant by mode |

## Verification
The bench builds five instances side by side with a 6-bit address and 8-bit data. They cover both speed grades and both output-enable modes, at clock periods of 8 ns and 20 ns. This gives high-Z waits of 0, 2, 4 and 5 cycles, write cycles of 5, 11 and 13 cycles, and cases where the address-to-end bound and the high-Z-plus-setup bound tie. All five instances share one stimulus stream: pseudo-random request pulses, a stretch of requests held high and an asynchronous reset in the middle of a write. Because each instance has a different cycle length, the same stream lands requests on every phase of a write, including the acknowledge edge and the edge just after it.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  // minimum times in ns for one speed grade
  typedef struct packed {
    int unsigned cyc;
    int unsigned pulse;
    int unsigned addr_end;
    int unsigned sel_end;
    int unsigned dsetup;
    int unsigned hiz;
  } sram_tim_t;

  function automatic sram_tim_t grade_tim(input int unsigned grade);
    sram_tim_t t;
    if (grade == 0) begin
      t.cyc = 85;  t.pulse = 55; t.addr_end = 75;
      t.sel_end = 75; t.dsetup = 40; t.hiz = 30;
    end else begin
      t.cyc = 100; t.pulse = 60; t.addr_end = 80;
      t.sel_end = 80; t.dsetup = 40; t.hiz = 35;
    end
    return t;
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (clr_i)     nxt_o = '0;
    else if (en_i) nxt_o = cnt_q + 1'b1;
    else           nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
  parameter int unsigned PULSE   = 10,
  parameter int unsigned HZ_WAIT = 4,
  parameter int unsigned CYCLE   = 11,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic             strobe_o,
  output logic             dq_oe_o,
  output logic             ack_o
);

  localparam logic [CNT_W-1:0] PULSE_V = CNT_W'(PULSE);
  localparam logic [CNT_W-1:0] HZ_V    = CNT_W'(HZ_WAIT);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(CYCLE - 1);

  logic busy_q, strobe_q, dq_oe_q, ack_q;
  logic accept, last, busy_d, in_pulse, after_hz;

  assign accept    = req_i && !busy_q;
  assign last      = busy_q && (cnt_i == LAST_V);
  assign busy_d    = accept || (busy_q && !last);
  assign in_pulse  = nxt_i < PULSE_V;

  // data drive wait: absent when the output enable is held high
  if (HZ_WAIT == 0) begin : g_no_hz
    assign after_hz = 1'b1;
  end else begin : g_hz
    assign after_hz = nxt_i >= HZ_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      dq_oe_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      strobe_q <= busy_d && in_pulse;
      dq_oe_q  <= busy_d && in_pulse && after_hz;
      ack_q    <= last;
    end
  end

  assign accept_o  = accept;
  assign busy_o    = busy_q;
  assign tmr_clr_o = accept;
  assign tmr_en_o  = busy_q;
  assign strobe_o  = strobe_q;
  assign dq_oe_o   = dq_oe_q;
  assign ack_o     = ack_q;

  // cycles the strobe has been high, for the checks below
  logic [CNT_W-1:0] lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_cnt <= '0;
    else if (strobe_q) lo_cnt <= lo_cnt + 1'b1;
    else               lo_cnt <= '0;
  end

  a_r3_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q) |-> lo_cnt == PULSE_V);

  a_r4_hz_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_q) |-> lo_cnt == HZ_V);

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q) |-> !dq_oe_q);

  a_r5_dq_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_q |-> strobe_q);

  a_r6_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  a_r6_ack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> !busy_q && !strobe_q);

  a_r8_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_q) |-> $past(!busy_q));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter bit          OE_TIED_LOW   = 1'b1,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_cs1_n_o,
  output logic              sram_cs2_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o
);

  localparam sram_tim_t   TIM     = grade_tim(SPEED_GRADE);
  localparam int unsigned WC_C    = ns_to_cyc(TIM.cyc, CLK_PERIOD_NS);
  localparam int unsigned WP_C    = ns_to_cyc(TIM.pulse, CLK_PERIOD_NS);
  localparam int unsigned AW_C    = ns_to_cyc(TIM.addr_end, CLK_PERIOD_NS);
  localparam int unsigned CW_C    = ns_to_cyc(TIM.sel_end, CLK_PERIOD_NS);
  localparam int unsigned DW_C    = ns_to_cyc(TIM.dsetup, CLK_PERIOD_NS);
  localparam int unsigned HZ_C    = ns_to_cyc(TIM.hiz, CLK_PERIOD_NS);
  localparam int unsigned HZ_WAIT = OE_TIED_LOW ? HZ_C : 0;
  localparam int unsigned PULSE   = umax(umax(WP_C, AW_C), umax(CW_C, HZ_WAIT + DW_C));
  localparam int unsigned CYCLE   = umax(WC_C, PULSE);
  localparam int unsigned CNT_W   = $clog2(CYCLE + 1);

  logic [CNT_W-1:0] cnt, nxt;
  logic tmr_clr, tmr_en, accept, busy, strobe, dq_oe;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .cnt_o  (cnt),
    .nxt_o  (nxt)
  );

  sram_wr_ctrl #(
    .PULSE   (PULSE),
    .HZ_WAIT (HZ_WAIT),
    .CYCLE   (CYCLE),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .cnt_i     (cnt),
    .nxt_i     (nxt),
    .accept_o  (accept),
    .busy_o    (busy),
    .tmr_clr_o (tmr_clr),
    .tmr_en_o  (tmr_en),
    .strobe_o  (strobe),
    .dq_oe_o   (dq_oe),
    .ack_o     (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  // one register drives all three strobes: start and end share an edge
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = data_q;
  assign sram_dq_oe_o = dq_oe;
  assign sram_cs1_n_o = ~strobe;
  assign sram_cs2_o   = strobe;
  assign sram_we_n_o  = ~strobe;
  assign sram_oe_n_o  = ~OE_TIED_LOW;

  a_r2_start_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe) |-> sram_addr_o == $past(addr_i));

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(sram_addr_o) && $stable(sram_dq_o));

endmodule

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;

  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;
  localparam int NCFG = 5;

  function automatic int unsigned cfg_per(input int i);
    return (i < 3) ? 8 : 20;
  endfunction
  function automatic int unsigned cfg_grade(input int i);
    case (i) 0, 1: return 0; 2, 3: return 1; default: return 0; endcase
  endfunction
  function automatic bit cfg_oe(input int i);
    return (i == 0 || i == 2 || i == 4);
  endfunction
  // ns values: 0 cycle, 1 pulse, 2 addr-to-end, 3 sel-to-end, 4 setup, 5 hiz
  function automatic int unsigned tns(input int unsigned g, input int k);
    case (k)
      0: return g ? 100 : 85;
      1: return g ? 60 : 55;
      2: return g ? 80 : 75;
      3: return g ? 80 : 75;
      4: return 40;
      default: return g ? 35 : 30;
    endcase
  endfunction
  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    int unsigned q;
    q = a / b;
    if (q * b != a) q = q + 1;
    return q;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    if (a >= b) return a;
    return b;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;

  always #4 clk = ~clk;

  for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
    localparam int unsigned PER = cfg_per(gi);
    localparam int unsigned GR  = cfg_grade(gi);
    localparam bit          OEL = cfg_oe(gi);
    localparam int unsigned H   = OEL ? cdiv(tns(GR, 5), PER) : 0;
    localparam int unsigned P   = mx(mx(cdiv(tns(GR, 1), PER), cdiv(tns(GR, 2), PER)),
                                     mx(cdiv(tns(GR, 3), PER), H + cdiv(tns(GR, 4), PER)));
    localparam int unsigned W   = mx(cdiv(tns(GR, 0), PER), P);

    logic cs1_n, cs2, we_n, oe_n, dq_oe, ack;
    logic [AW-1:0] a;
    logic [DW-1:0] d;

    sram_wr_seq #(
      .CLK_PERIOD_NS (PER),
      .SPEED_GRADE   (GR),
      .OE_TIED_LOW   (OEL),
      .ADDR_W        (AW),
      .DATA_W        (DW)
    ) uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_i        (req),
      .addr_i       (in_addr),
      .data_i       (in_data),
      .ack_o        (ack),
      .sram_addr_o  (a),
      .sram_dq_o    (d),
      .sram_dq_oe_o (dq_oe),
      .sram_cs1_n_o (cs1_n),
      .sram_cs2_o   (cs2),
      .sram_we_n_o  (we_n),
      .sram_oe_n_o  (oe_n)
    );

    logic m_busy, m_ack;
    int unsigned k;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;
    int n_chk = 0, n_err = 0, run_lo = 0, n_ack = 0, m_ackcnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
        n_err++;
        $display("FAIL cfg%0d %s act=%0h exp=%0h t=%0t", gi, tag, act, exp, $time);
      end
    endtask

    // reference model, from the requirements
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_busy <= 1'b0; m_ack <= 1'b0; k <= 0;
      end else if (m_busy) begin
        if (k == W - 1) begin
          m_busy <= 1'b0; m_ack <= 1'b1; m_ackcnt <= m_ackcnt + 1;
        end else k <= k + 1;
      end else begin
        m_ack <= 1'b0;
        if (req) begin
          m_busy <= 1'b1; k <= 0; m_addr <= in_addr; m_data <= in_data;
        end
      end
    end

    always @(negedge clk) begin
      logic s, o;
      if (!rst_n) begin
        chk({cs1_n, cs2, we_n, dq_oe, ack} == 5'b10100, "R1 reset outputs",
            32'({cs1_n, cs2, we_n, dq_oe, ack}), 32'h14);
        run_lo = 0;
      end else begin
        s = m_busy && (k < P);
        o = m_busy && (k >= H) && (k < P);
        chk({cs1_n, cs2, we_n} == {~s, s, ~s}, "R2 R3 strobes",
            32'({cs1_n, cs2, we_n}), 32'({~s, s, ~s}));
        chk(dq_oe == o, "R4 R5 data drive", 32'(dq_oe), 32'(o));
        chk(ack == m_ack, "R6 ack", 32'(ack), 32'(m_ack));
        chk(oe_n == !OEL, "R4 oe pin", 32'(oe_n), 32'(!OEL));
        if (m_busy || m_ack)
          chk(a == m_addr, "R7 R8 address hold", 32'(a), 32'(m_addr));
        if (o)
          chk(d == m_data, "R7 R8 data hold", 32'(d), 32'(m_data));
        if (ack) n_ack++;
        if (!we_n) run_lo++;
        else begin
          if (run_lo != 0)
            chk(run_lo == P, "R3 R9 R10 pulse length", 32'(run_lo), 32'(P));
          run_lo = 0;
        end
      end
    end
  end

  int t_chk = 0, t_err = 0;
  bit finished = 1'b0;

  task automatic tchk(input bit ok, input string tag, input int act, input int exp);
    t_chk++;
    if (!ok) begin
      t_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    int c, e;
    c = t_chk + g_cfg[0].n_chk + g_cfg[1].n_chk + g_cfg[2].n_chk + g_cfg[3].n_chk + g_cfg[4].n_chk;
    e = t_err + g_cfg[0].n_err + g_cfg[1].n_err + g_cfg[2].n_err + g_cfg[3].n_err + g_cfg[4].n_err;
    $display("End of test - %0d assertions evaluated, %0d failures", c, e);
  endtask

  task automatic step(input logic r, input logic [15:0] v);
    @(negedge clk); #1;
    req = r; in_addr = v[AW-1:0]; in_data = v[15:8];
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // sparse pseudo-random requests: land on every phase, incl. the ack edge
    for (int i = 0; i < 220; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0] == 2'b00, lf);
    end
    // requests held high: back-to-back writes, R8
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1'b1, lf);
    end
    // reset in the middle of a write, R1
    step(1'b0, lf);
    step(1'b1, 16'h5A3C);
    step(1'b0, 16'h0000);
    step(1'b0, 16'h0000);
    #1 rst_n = 1'b0;
    repeat (3) step(1'b1, 16'hFFFF);
    @(negedge clk); #1 rst_n = 1'b1; req = 1'b0;
    step(1'b1, 16'h1234);
    step(1'b0, 16'h0000);
    repeat (30) step(1'b0, 16'h0000);
    // R6: every acknowledge the model expects was seen, and enough writes ran
    tchk(g_cfg[0].n_ack == g_cfg[0].m_ackcnt, "R6 ack count cfg0", g_cfg[0].n_ack, g_cfg[0].m_ackcnt);
    tchk(g_cfg[1].n_ack == g_cfg[1].m_ackcnt, "R6 ack count cfg1", g_cfg[1].n_ack, g_cfg[1].m_ackcnt);
    tchk(g_cfg[2].n_ack == g_cfg[2].m_ackcnt, "R6 ack count cfg2", g_cfg[2].n_ack, g_cfg[2].m_ackcnt);
    tchk(g_cfg[3].n_ack == g_cfg[3].m_ackcnt, "R6 ack count cfg3", g_cfg[3].n_ack, g_cfg[3].m_ackcnt);
    tchk(g_cfg[4].n_ack == g_cfg[4].m_ackcnt, "R6 ack count cfg4", g_cfg[4].n_ack, g_cfg[4].m_ackcnt);
    tchk(g_cfg[2].m_ackcnt > 10, "R6 writes completed cfg2", g_cfg[2].m_ackcnt, 11);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      t_chk++;
      t_err++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

endmodule